// File: doc/BRIEF.md
# HART Character Serializer with RTS/CTS Gating

This block turns bytes waiting in a transmit FIFO into the serial character stream that feeds a HART FSK modulator. It runs from the 1.2288 MHz modem master clock and divides it down to 1200 baud (1024 clocks per bit). The host raises a request-to-send input. That turns the modulator enable on, and after a programmable number of bit times an internal clear-to-send comes up. From then on the block pulls one FIFO entry per character without any further host action. Each entry holds a data byte and a host-supplied parity bit.

Every character is 11 bit periods long: a 0 start bit, the eight data bits least-significant first, the stored parity bit and a 1 stop bit. When the FIFO runs dry while request-to-send is still high, the modulator stays enabled and the line rests at 1. A busy status output covers the end-of-transmission latency. It goes high at the first fetch and stays high until 12.5 bit times after the most recent fetch, so the host knows when request-to-send can be dropped without a gap error.

Top module: `hart_char_tx`

## Requirements
- R1: During and right after synchronous reset, tx_bit is 1 and mod_en, cts, busy and fifo_pop are 0.
- R2: Each transmitted bit holds tx_bit for exactly CLKS_PER_BIT clocks (default 1024, which gives 1200 baud from 1.2288 MHz).
- R3: A character is sent as bit 0 = start (0), bits 1..8 = data[0]..data[7], bit 9 = parity, bit 10 = stop (1). The start bit appears on the clock edge that takes the entry.
- R4: The parity bit sent is the stored fifo_par value exactly, even when it does not give odd parity over the data.
- R5: cts rises on the (cts_delay*CLKS_PER_BIT+1)-th clock edge counted from the first edge that sees rts high. cts is cleared on the first edge that sees rts low.
- R6: fifo_pop is a single-cycle pulse. It is issued only on a bit boundary while rts and cts are high and the FIFO is not empty, so the first fetch comes (cts_delay+1)*CLKS_PER_BIT-1 clocks after the edge that first sees rts high. With rts low, no entry is taken.
- R7: Back-to-back characters are fetched exactly 11*CLKS_PER_BIT clocks apart, with no idle bit between them.
- R8: With rts high and the FIFO empty after a character, mod_en stays 1 and tx_bit stays 1.
- R9: busy goes high on the edge after a fetch and falls exactly LAT_HALF_BITS*CLKS_PER_BIT/2 clocks (12.5 bit times by default) after the last fetch edge.
- R10: Dropping rts in the middle of a character lets that character finish with mod_en held high. No further entry is fetched, and mod_en falls after the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rts | input | 1 | Request to send from host |
| cts_delay | input | CTS_DW | Bit times from rts to cts |
| fifo_empty | input | 1 | Transmit FIFO holds no entry |
| fifo_data | input | 8 | Data byte at FIFO head |
| fifo_par | input | 1 | Stored parity bit at FIFO head |
| fifo_pop | output | 1 | Fetch strobe, takes the head entry |
| mod_en | output | 1 | Modulator enable |
| cts | output | 1 | Clear to send |
| tx_bit | output | 1 | Serial bit to the FSK modulator |
| busy | output | 1 | Transmission latency window active |

## Verification
The bench samples every bit of every character at its centre, counting from the fetch strobe. A design with the wrong bit order, a start or stop bit of the wrong polarity, or a parity bit it computes itself would put a wrong bit at one of those points. Deliberately stored even-parity entries show whether the stored bit is passed through. It times cts and the first fetch from the rise of rts, the spacing of back-to-back fetches and the fall of busy after the last fetch. An off-by-one in the divider, an idle bit inserted between characters, or a latency timer counted from the stop bit would each change one of those counts. It drops rts in the middle of a character with another entry waiting. A design that cuts the character short or fetches once more fails here, and so does one that lets the line float or turns the modulator off while the FIFO is merely empty.

// File: rtl/hart_tx_pkg.sv
package hart_tx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int LAST_IDX   = FRAME_BITS - 1;

    typedef struct packed {
        logic       par;
        logic [7:0] data;
    } hart_char_t;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;

    // Bit 0 goes out first: start, data LSB first, parity, stop.
    function automatic logic [FRAME_BITS-1:0] build_frame(input hart_char_t c);
        return {1'b1, c.par, c.data, 1'b0};
    endfunction

endpackage

// File: rtl/hart_baud_gen.sv
module hart_baud_gen #(
    parameter int CLKS_PER_BIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == TOP)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == TOP);

    // R2: no tick while the modulator clock domain is stopped
    a_r2_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/hart_cts_gen.sv
module hart_cts_gen #(
    parameter int CTS_DW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rts,
    input  logic              tick,
    input  logic [CTS_DW-1:0] delay,
    output logic              cts
);
    logic [CTS_DW-1:0] bits_q;
    logic              cts_q;

    always_ff @(posedge clk) begin
        if (rst || !rts) begin
            bits_q <= '0;
            cts_q  <= 1'b0;
        end else if (!cts_q) begin
            if (bits_q == delay)
                cts_q <= 1'b1;
            else if (tick)
                bits_q <= bits_q + 1'b1;
        end
    end

    assign cts = cts_q;

    // R5: clear-to-send is withdrawn as soon as request-to-send drops
    a_r5_cts_drops: assert property (@(posedge clk) disable iff (rst)
        !rts |=> !cts_q);
endmodule

// File: rtl/hart_char_serializer.sv
module hart_char_serializer
    import hart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rts,
    input  logic       cts,
    input  logic       fifo_empty,
    input  hart_char_t head,
    output logic       fetch,
    output logic       tx_bit,
    output logic       sending
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST = IW'(LAST_IDX);

    ser_state_e            st_q;
    logic [IW-1:0]         idx_q;
    logic [FRAME_BITS-2:0] rest_q;
    logic                  tx_q;
    logic [FRAME_BITS-1:0] frame_d;
    logic                  at_boundary;

    assign frame_d     = build_frame(head);
    assign at_boundary = (st_q == SER_IDLE) || (idx_q == LAST);
    assign fetch       = tick && rts && cts && !fifo_empty && at_boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SER_IDLE;
            idx_q  <= '0;
            rest_q <= '1;
            tx_q   <= 1'b1;
        end else if (fetch) begin
            st_q   <= SER_SEND;
            idx_q  <= '0;
            tx_q   <= frame_d[0];
            rest_q <= frame_d[FRAME_BITS-1:1];
        end else if (tick && st_q == SER_SEND) begin
            if (idx_q == LAST) begin
                st_q <= SER_IDLE;
                tx_q <= 1'b1;
            end else begin
                tx_q   <= rest_q[0];
                rest_q <= {1'b1, rest_q[FRAME_BITS-2:1]};
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    assign tx_bit  = tx_q;
    assign sending = (st_q == SER_SEND);

    // R2: the line only moves on a bit boundary
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tx_q));
    // R6: a fetch strobe never lasts two cycles
    a_r6_single_pop: assert property (@(posedge clk) disable iff (rst)
        fetch |=> !fetch);
endmodule

// File: rtl/hart_latency_timer.sv
module hart_latency_timer #(
    parameter int LAT_CLKS = 12800
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int LW = $clog2(LAT_CLKS + 1);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (load)
            left_q <= LW'(LAT_CLKS);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/hart_char_tx.sv
module hart_char_tx
    import hart_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT  = 1024,
    parameter int LAT_HALF_BITS = 25,
    parameter int CTS_DW        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rts,
    input  logic [CTS_DW-1:0] cts_delay,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_par,
    output logic              fifo_pop,
    output logic              mod_en,
    output logic              cts,
    output logic              tx_bit,
    output logic              busy
);
    localparam int LAT_CLKS = (LAT_HALF_BITS * CLKS_PER_BIT) / 2;

    logic       tick;
    logic       sending;
    hart_char_t head;

    assign head   = '{par: fifo_par, data: fifo_data};
    assign mod_en = rts || sending;

    hart_baud_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk (clk),
        .rst (rst),
        .run (mod_en),
        .tick(tick)
    );

    hart_cts_gen #(.CTS_DW(CTS_DW)) u_cts (
        .clk  (clk),
        .rst  (rst),
        .rts  (rts),
        .tick (tick),
        .delay(cts_delay),
        .cts  (cts)
    );

    hart_char_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rts       (rts),
        .cts       (cts),
        .fifo_empty(fifo_empty),
        .head      (head),
        .fetch     (fifo_pop),
        .tx_bit    (tx_bit),
        .sending   (sending)
    );

    hart_latency_timer #(.LAT_CLKS(LAT_CLKS)) u_lat (
        .clk (clk),
        .rst (rst),
        .load(fifo_pop),
        .busy(busy)
    );

    // R9: the latency window opens with every fetch
    a_r9_busy_follows_fetch: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> busy);
    // R8: outside the latency window the line rests at mark
    a_r8_idle_mark: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_bit);
    // R10: with the modulator off the line is at 1
    a_r10_off_is_mark: assert property (@(posedge clk) disable iff (rst)
        !mod_en |-> tx_bit);
    // R5: clear-to-send only follows an asserted request
    a_r5_cts_needs_rts: assert property (@(posedge clk) disable iff (rst)
        cts |-> $past(rts));
endmodule

// File: tb/hart_char_tx_tb.sv
module hart_char_tx_tb;
    localparam int CPB = 16;
    localparam int LHB = 25;
    localparam int LAT = (LHB * CPB) / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rts = 1'b0;
    logic [3:0] cts_delay = 4'd0;
    logic       fifo_empty, fifo_par, fifo_pop, mod_en, cts, tx_bit, busy;
    logic [7:0] fifo_data;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    hart_char_tx #(.CLKS_PER_BIT(CPB), .LAT_HALF_BITS(LHB), .CTS_DW(4)) u_dut (
        .clk(clk), .rst(rst), .rts(rts), .cts_delay(cts_delay),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_par(fifo_par),
        .fifo_pop(fifo_pop), .mod_en(mod_en), .cts(cts), .tx_bit(tx_bit),
        .busy(busy)
    );

    // FIFO model
    logic [8:0] mem [16];
    logic [3:0] wp = 4'd0;
    logic [3:0] rp;
    always @(posedge clk) begin
        if (rst) rp <= 4'd0;
        else if (fifo_pop) rp <= rp + 4'd1;
    end
    assign fifo_empty = (wp == rp);
    assign fifo_data  = mem[rp][7:0];
    assign fifo_par   = mem[rp][8];

    logic [10:0] exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: one entry into the FIFO, one expected frame into the scoreboard
    task automatic push_char(input logic [7:0] d, input logic p);
        mem[wp] = {p, d};
        wp = wp + 4'd1;
        exp_q.push_back({1'b1, p, d, 1'b0});
    endtask

    // Timestamps of fetches and of busy falling, from one process
    int ncyc = 0;
    int pop_cnt = 0;
    int pt [16];
    int fall_t = 0;
    int fall_cnt = 0;
    logic busy_prev = 1'b0;
    always @(negedge clk) begin
        ncyc++;
        if (!rst && fifo_pop) begin
            if (pop_cnt < 16) pt[pop_cnt] = ncyc;
            pop_cnt++;
        end
        if (busy_prev && !busy) begin
            fall_t = ncyc;
            fall_cnt++;
        end
        busy_prev = busy;
    end

    // Monitor: sample each bit of a character at its centre (R2, R3, R4)
    initial begin
        logic [10:0] fr;
        forever begin
            @(negedge clk);
            if (!rst && fifo_pop) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "fetch with no expected frame", 1, 0);
                end else begin
                    fr = exp_q.pop_front();
                    for (int k = 0; k < 11; k++) begin
                        repeat ((k == 0) ? (CPB / 2 + 1) : CPB) @(negedge clk);
                        check(tx_bit == fr[k], (k == 9) ? "R4" : "R3",
                              $sformatf("frame bit %0d of 0x%02h", k, fr[8:1]),
                              int'(tx_bit), int'(fr[k]));
                    end
                end
            end
        end
    end

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_up();
    end

    initial begin
        int n, n_cts, n_pop, p0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(tx_bit == 1'b1, "R1", "tx_bit in reset", int'(tx_bit), 1);
        check({mod_en, cts, busy, fifo_pop} == 4'b0, "R1", "outputs in reset",
              int'({mod_en, cts, busy, fifo_pop}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({mod_en, cts, busy, fifo_pop, tx_bit} == 5'b00001, "R1",
              "outputs after reset", int'({mod_en, cts, busy, fifo_pop, tx_bit}), 1);

        // R6: loaded FIFO, rts low -> nothing fetched
        push_char(8'hFF, 1'b1);
        push_char(8'h00, 1'b0);   // stored parity is even on purpose (R4)
        push_char(8'hA5, 1'b1);
        push_char(8'h3C, 1'b0);   // even again (R4)
        repeat (100) @(negedge clk);
        check(pop_cnt == 0 && tx_bit && !mod_en, "R6", "no fetch with rts low",
              pop_cnt, 0);

        // R5/R6: cts timing and first fetch position
        cts_delay = 4'd2;
        rts = 1'b1;
        n = 0; n_cts = -1; n_pop = -1;
        while (n < 200 && n_pop < 0) begin
            @(negedge clk);
            n++;
            if (cts && n_cts < 0) n_cts = n;
            if (fifo_pop && n_pop < 0) n_pop = n;
        end
        check(n_cts == 2 * CPB + 1, "R5", "edges from rts to cts", n_cts, 2 * CPB + 1);
        check(n_pop == 3 * CPB - 1, "R6", "edges from rts to first fetch", n_pop, 3 * CPB - 1);

        // R7/R9: back-to-back spacing, then latency window
        wait (pop_cnt == 4);
        wait (fall_cnt == 1);
        for (int i = 1; i < 4; i++)
            check(pt[i] - pt[i-1] == 11 * CPB, "R7", $sformatf("fetch gap %0d", i),
                  pt[i] - pt[i-1], 11 * CPB);
        check(fall_t - pt[3] == LAT + 1, "R9", "busy fall after last fetch",
              fall_t - pt[3], LAT + 1);
        check(exp_q.size() == 0, "R3", "frames left after burst", exp_q.size(), 0);

        // R8: empty FIFO, rts high -> mark with modulator on
        n = 0;
        p0 = pop_cnt;
        for (int i = 0; i < 3 * CPB; i++) begin
            @(negedge clk);
            if (!tx_bit || !mod_en) n++;
        end
        check(n == 0 && pop_cnt == p0, "R8", "idle cycles off mark", n, 0);

        // R10: rts dropped mid-character
        push_char(8'h5A, 1'b1);
        push_char(8'hC3, 1'b0);
        wait (pop_cnt == 5);
        repeat (3 * CPB) @(negedge clk);
        rts = 1'b0;
        @(negedge clk);
        check(cts == 1'b0, "R5", "cts after rts low", int'(cts), 0);
        check(mod_en == 1'b1, "R10", "mod_en during open character", int'(mod_en), 1);
        repeat (10 * CPB) @(negedge clk);
        check(pop_cnt == 5, "R10", "fetches after rts drop", pop_cnt, 5);
        check(!mod_en && tx_bit, "R10", "mod_en/tx_bit after stop bit",
              int'({mod_en, tx_bit}), 1);
        check(exp_q.size() == 1, "R10", "frames pending after drop", exp_q.size(), 1);

        // Flush the waiting entry with zero cts delay
        cts_delay = 4'd0;
        rts = 1'b1;
        wait (pop_cnt == 6);
        repeat (12 * CPB) @(negedge clk);
        check(exp_q.size() == 0, "R3", "frames left at end", exp_q.size(), 0);
        rts = 1'b0;
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule